// File: doc/BRIEF.md
# Ping-Pong Block Interleaver Buffer Controller

This block runs a streaming block interleaver or deinterleaver over two single-port RAMs used as a ping-pong pair. Soft values arrive on a valid-qualified input. One RAM collects the current block while the other RAM plays the previous block out. The output is also valid-qualified. Each RAM has its own address multiplexer. In a given cycle that multiplexer passes either the write address or the read address, never both.

The permutation itself is computed outside the block. The controller shows a position index on `perm_idx` and takes the permuted address back on `perm_addr` in the same cycle. A single mode pin decides which side of the buffer uses the permuted address:

- When interleaving, writes are scattered through the permuted address and reads are sequential.
- When deinterleaving, writes are sequential and reads are gathered through the permuted address.

So both directions share one datapath. A small table selects the block length. A synchronous soft clear abandons all work in flight.

Top module: `ilv_pingpong`

## Requirements
- R1: After `rst_n` is released, `out_valid` is low and stays low until a complete block has been entered.
- R2: The first block of a run is written into buffer A. Output begins in the cycle after the edge that accepts the last value of that block, with block position 0 first.
- R3: In interleave mode (`deint_mode`=0), `perm_idx` carries the write count k. Input value k is stored at `perm_addr` and read back sequentially, so output position `perm_addr(k)` equals input k.
- R4: In deinterleave mode (`deint_mode`=1), `perm_idx` carries the read count j. Writes are sequential, so output position j equals input `perm_addr(j)`. Gaps in `in_valid` inside a block are allowed.
- R5: Back-to-back blocks alternate between the two buffers. Their outputs follow one another with no idle cycle between blocks.
- R6: A buffer is never written and read in the same cycle, and at most one buffer is read per cycle.
- R7: `deint_mode` and `cfg_sel` are captured on the first accepted value of a run. Changes while a run is active have no effect on the output.
- R8: Block length by `cfg_sel` is 0→48, 1→96, 2→192 and 3→648, in a 672-entry RAM of 6-bit values.
- R9: A cycle with `soft_clr` high returns the block to idle from any state. It ignores that cycle's input, discards the partial block and any unread block, and drives `out_valid` low on the next cycle.
- R10: When input stops, `out_valid` falls right after the last buffered value is delivered. The block then goes idle, and the next accepted value starts a new run with new settings.
- R11: A block passed through interleave mode and then through deinterleave mode, with the same generator, comes back in its original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Synchronous soft clear, active high |
| deint_mode | input | 1 | 0 interleave, 1 deinterleave (sampled at start of run) |
| cfg_sel | input | 2 | Block length select (sampled at start of run) |
| in_valid | input | 1 | Input value qualifier |
| in_data | input | 6 | Input soft value |
| perm_idx | output | 10 | Position handed to the external permutation generator |
| perm_addr | input | 10 | Permuted address returned combinationally |
| out_valid | output | 1 | Output value qualifier |
| out_data | output | 6 | Output soft value |

## Verification
The bench goes after several corner cases, each tied to a distinct way the design could fail:

- The hand-over cycle where one block's last read coincides with the next block's completion. A design that reset the read pointer late would leave a one-cycle hole or repeat a value.
- Input streams with gaps.
- Settings changed in the middle of a run. A design that did not latch them would scramble the second block.
- A soft clear both during filling and during playback. A wrong design would leak stale values or resume a half-written block.
- An interleave run followed by a deinterleave run on the longest block. This exposes any swap of the write and read address roles, because the test permutation is deliberately not its own inverse.

// File: rtl/ilv_pkg.sv
// Shared types and the block-length table for the ping-pong interleaver.
// Assumes cfg codes beyond the table fall back to the shortest block.
package ilv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } ilv_state_t;

    // Block length in values for each configuration code.
    function automatic int block_len(input int code);
        case (code)
            1:       return 96;
            2:       return 192;
            3:       return 648;
            default: return 48;
        endcase
    endfunction

endpackage

// File: rtl/ilv_spram.sv
// Behavioural single-port RAM: one address bus shared by write and read.
// Assumes a read result is needed one clock after the address is presented.
module ilv_spram #(
    parameter int DW    = 6,
    parameter int DEPTH = 672,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Either store the input or register the addressed word.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/ilv_ctrl.sv
// Control for the ping-pong interleaver: run state, write and read counters,
// buffer roles, and the swap of the permuted address between write and read.
// Assumes the input never outruns playback (one write per cycle at most).
module ilv_ctrl
    import ilv_pkg::*;
#(
    parameter int DEPTH = 672,
    parameter int CFG_W = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             deint_in,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic             in_valid,
    input  logic [AW-1:0]    perm_addr,
    output logic [AW-1:0]    perm_idx,
    output logic             wr_go,
    output logic             wr_buf,
    output logic [AW-1:0]    wr_addr,
    output logic             rd_on,
    output logic             rd_buf,
    output logic [AW-1:0]    rd_addr,
    output ilv_state_t       st,
    output logic             deint_q,
    output logic [AW-1:0]    len_q
);
    logic [AW-1:0] wr_cnt, rd_cnt, cur_len;
    logic          wr_buf_q, cur_deint, idle, blk_done, rd_last;

    // Settings come straight from the pins while idle, else from the latch.
    assign idle      = (st == ST_IDLE);
    assign cur_deint = idle ? deint_in : deint_q;
    assign cur_len   = idle ? AW'(block_len(int'(cfg_in))) : len_q;

    // Accept and finish conditions for both sides of the buffer.
    assign wr_go    = in_valid && !soft_clr;
    assign blk_done = wr_go && (wr_cnt == cur_len - AW'(1));
    assign rd_last  = rd_on && (rd_cnt == len_q - AW'(1));
    assign wr_buf   = idle ? 1'b0 : wr_buf_q;

    // Mode picks which side uses the permuted address.
    assign perm_idx = cur_deint ? rd_cnt : wr_cnt;
    assign wr_addr  = cur_deint ? wr_cnt : perm_addr;
    assign rd_addr  = cur_deint ? perm_addr : rd_cnt;

    // Sequencing of counters, buffer roles and run state.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            st       <= ST_IDLE;
            wr_cnt   <= '0;
            rd_cnt   <= '0;
            rd_on    <= 1'b0;
            rd_buf   <= 1'b0;
            wr_buf_q <= 1'b0;
            deint_q  <= 1'b0;
            len_q    <= AW'(block_len(0));
        end else begin
            if (idle) begin
                deint_q <= deint_in;
                len_q   <= cur_len;
            end
            if (wr_go) wr_cnt <= blk_done ? '0 : wr_cnt + AW'(1);
            if (blk_done)  wr_buf_q <= ~wr_buf;
            else if (idle) wr_buf_q <= 1'b0;
            if (blk_done) begin
                rd_on  <= 1'b1;
                rd_buf <= wr_buf;
                rd_cnt <= '0;
            end else if (rd_last) begin
                rd_on  <= 1'b0;
                rd_cnt <= '0;
            end else if (rd_on) begin
                rd_cnt <= rd_cnt + AW'(1);
            end
            case (st)
                ST_IDLE: if (wr_go) st <= ST_FILL;
                ST_FILL: if (blk_done) st <= ST_RUN;
                ST_RUN:  if (rd_last && !wr_go && wr_cnt == '0) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ilv_pingpong.sv
// Top of the ping-pong interleaver: two single-port RAMs, one address
// multiplexer per RAM, and the registered output select.
// Assumes an external generator returns perm_addr in the same cycle.
module ilv_pingpong
    import ilv_pkg::*;
#(
    parameter int DW    = 6,
    parameter int DEPTH = 672,
    parameter int CFG_W = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             deint_mode,
    input  logic [CFG_W-1:0] cfg_sel,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    output logic [AW-1:0]    perm_idx,
    input  logic [AW-1:0]    perm_addr,
    output logic             out_valid,
    output logic [DW-1:0]    out_data
);
    logic          wr_go, wr_buf, rd_on, rd_buf, deint_q, sel_q;
    logic [AW-1:0] wr_addr, rd_addr, len_q;
    logic [1:0]    wr_sel, rd_sel;
    logic [DW-1:0] q [2];
    ilv_state_t    st;

    ilv_ctrl #(.DEPTH(DEPTH), .CFG_W(CFG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .deint_in(deint_mode), .cfg_in(cfg_sel), .in_valid(in_valid),
        .perm_addr(perm_addr), .perm_idx(perm_idx),
        .wr_go(wr_go), .wr_buf(wr_buf), .wr_addr(wr_addr),
        .rd_on(rd_on), .rd_buf(rd_buf), .rd_addr(rd_addr),
        .st(st), .deint_q(deint_q), .len_q(len_q)
    );

    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic [AW-1:0] addr;
        // Per-RAM role decode and address multiplexer.
        assign wr_sel[b] = wr_go && (wr_buf == 1'(b));
        assign rd_sel[b] = rd_on && (rd_buf == 1'(b));
        assign addr      = wr_sel[b] ? wr_addr : rd_addr;

        ilv_spram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
            .clk(clk), .en(wr_sel[b] | rd_sel[b]), .we(wr_sel[b]),
            .addr(addr), .wdata(in_data), .rdata(q[b])
        );
    end

    // Output qualifier follows the read by one cycle, as does the RAM select.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            out_valid <= 1'b0;
            sel_q     <= 1'b0;
        end else begin
            out_valid <= rd_on;
            sel_q     <= rd_buf;
        end
    end

    assign out_data = sel_q ? q[1] : q[0];
endmodule

// File: rtl/ilv_pingpong_chk.sv
// Protocol checks for the ping-pong interleaver, attached by bind.
// Assumes internal control signals are brought out by the bind connection.
module ilv_pingpong_chk
    import ilv_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_clr,
    input logic          out_valid,
    input ilv_state_t    st,
    input logic [1:0]    wr_sel,
    input logic [1:0]    rd_sel,
    input logic          rd_on,
    input logic          deint_q,
    input logic [AW-1:0] len_q
);
    p_no_early_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL) |-> !rd_on);

    p_port_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel & rd_sel) == 2'b00);

    p_one_reader_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_sel));

    p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> ($stable(deint_q) && $stable(len_q)));

    p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (st == ST_IDLE && !out_valid));

    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_IDLE) |-> !out_valid);
endmodule

bind ilv_pingpong ilv_pingpong_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .out_valid(out_valid),
    .st(st), .wr_sel(wr_sel), .rd_sel(rd_sel), .rd_on(rd_on),
    .deint_q(deint_q), .len_q(len_q)
);

// File: tb/ilv_pingpong_test.sv
// Bench: behavioural queue model predicts out_valid/out_data each cycle.
module ilv_pingpong_test;
    localparam int AW = 10;

    logic clk = 0, rst_n = 0, soft_clr = 0, deint_mode = 0, in_valid = 0;
    logic [1:0] cfg_sel = 0;
    logic [5:0] in_data = 0;
    logic [AW-1:0] perm_idx, perm_addr;
    logic out_valid;
    logic [5:0] out_data;

    int compared = 0, mismatched = 0, cyc = 0, wd = 0;
    bit run_chk = 0, cap_en = 0, ev;
    string cur_req = "R1";
    int m_len = 48, n_out = 0;
    bit m_deint = 0;
    logic [5:0] blk[$], eq_d[$], cap[$];
    int eq_t[$];
    logic [5:0] tmp [648];
    logic [5:0] orig [648];
    logic [5:0] mid [648];

    always #10 clk = ~clk;

    ilv_pingpong uut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .deint_mode(deint_mode),
        .cfg_sel(cfg_sel), .in_valid(in_valid), .in_data(in_data),
        .perm_idx(perm_idx), .perm_addr(perm_addr),
        .out_valid(out_valid), .out_data(out_data)
    );

    // External generator: rotate-and-scale inside groups of 8 (not self-inverse).
    assign perm_addr = {perm_idx[AW-1:3], 3'(perm_idx[2:0] * 3'd3 + 3'd1)};

    function automatic int pf(int k);
        return (k & ~7) | ((3 * (k & 7) + 1) & 7);
    endfunction

    function automatic int blen(int c);
        return (c == 1) ? 96 : (c == 2) ? 192 : (c == 3) ? 648 : 48;
    endfunction

    // Reference model, sampled on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n || soft_clr) begin
            blk.delete(); eq_d.delete(); eq_t.delete();
        end else if (in_valid) begin
            if (blk.size() == 0 && eq_d.size() == 0) begin
                m_len = blen(int'(cfg_sel));
                m_deint = deint_mode;
            end
            blk.push_back(in_data);
            if (blk.size() == m_len) begin
                for (int k = 0; k < m_len; k++) begin
                    if (m_deint) tmp[k] = blk[pf(k)];
                    else         tmp[pf(k)] = blk[k];
                end
                for (int j = 0; j < m_len; j++) begin
                    eq_d.push_back(tmp[j]);
                    eq_t.push_back(cyc + 1 + j);
                end
                blk.delete();
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            ev = (eq_t.size() > 0) && (eq_t[0] == cyc);
            compared++;
            if (out_valid !== ev) begin
                mismatched++;
                $display("FAIL %s cyc %0d: out_valid=%0b expected %0b", cur_req, cyc, out_valid, ev);
            end else if (ev && out_data !== eq_d[0]) begin
                mismatched++;
                $display("FAIL %s cyc %0d: out_data=%0h expected %0h", cur_req, cyc, out_data, eq_d[0]);
            end
            if (out_valid) begin
                n_out++;
                if (cap_en) cap.push_back(out_data);
            end
            if (ev) begin
                void'(eq_d.pop_front());
                void'(eq_t.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd == 100000) begin
            mismatched++;
            $display("FAIL watchdog: cycles=%0d expected < %0d", wd, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(logic [5:0] d);
        @(negedge clk);
        in_valid = 1; in_data = d;
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    task automatic clear_pulse();
        @(negedge clk);
        soft_clr = 1; in_valid = 1; in_data = 6'h3f;
        @(negedge clk);
        soft_clr = 0; in_valid = 0;
        check("R9 out_valid after clear", int'(out_valid), 0);
    endtask

    initial begin
        quiet(4);
        rst_n = 1;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
        run_chk = 1;
        quiet(5);

        // R2 / R3: first block, interleave, 48 values
        cur_req = "R2"; n_out = 0;
        for (int i = 0; i < 48; i++) send(6'(i));
        cur_req = "R3";
        quiet(60);
        check("R3 output count", n_out, 48);

        // R5 / R6: three back-to-back blocks without gaps
        cur_req = "R5"; n_out = 0;
        for (int i = 0; i < 144; i++) send(6'(i * 5 + 3));
        quiet(60);
        check("R5 output count", n_out, 144);

        // R4 with input gaps; R7 pin changes mid-run are ignored
        cur_req = "R4"; cfg_sel = 1; deint_mode = 1; n_out = 0;
        for (int i = 0; i < 192; i++) begin
            send(6'(i * 11 + 1));
            if (i == 50) begin cur_req = "R7"; deint_mode = 0; cfg_sel = 2; end
            if (i % 5 == 4) quiet(1);
        end
        quiet(120);
        check("R7 output count", n_out, 192);

        // R10: drained run returns quiet and takes new settings
        cur_req = "R10"; n_out = 0;
        quiet(20);
        check("R10 quiet after drain", n_out, 0);

        // R8: 192 interleave
        cur_req = "R8"; cfg_sel = 2; deint_mode = 0; n_out = 0;
        for (int i = 0; i < 192; i++) send(6'(i ^ 6'h15));
        quiet(220);
        check("R8 output count 192", n_out, 192);

        // R11: 648 interleave, then deinterleave back
        cur_req = "R11"; cfg_sel = 3; deint_mode = 0; cap.delete(); cap_en = 1;
        for (int i = 0; i < 648; i++) begin
            orig[i] = 6'((i * 37 + 9) >> 1);
            send(orig[i]);
        end
        quiet(670);
        check("R8 output count 648", cap.size(), 648);
        for (int i = 0; i < 648; i++) mid[i] = cap[i];
        cap.delete(); deint_mode = 1;
        for (int i = 0; i < 648; i++) send(mid[i]);
        quiet(670);
        cap_en = 0;
        check("R11 round trip count", cap.size(), 648);
        for (int i = 0; i < 648 && i < cap.size(); i++)
            if (cap[i] !== orig[i]) check("R11 round trip value", int'(cap[i]), int'(orig[i]));
        compared++;

        // R9: soft clear while filling and while playing back
        cur_req = "R9"; cfg_sel = 0; deint_mode = 0;
        for (int i = 0; i < 20; i++) send(6'(i + 7));
        clear_pulse();
        for (int i = 0; i < 58; i++) send(6'(i * 3));
        clear_pulse();
        quiet(10);
        n_out = 0;
        for (int i = 0; i < 48; i++) send(6'(63 - i));
        quiet(60);
        check("R9 fresh block after clear", n_out, 48);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule